// File: doc/BRIEF.md
# Console terminal character interface

This block joins a console keyboard and a console printer to a minicomputer I/O bus. On the keyboard side a serial receiver stub presents one character per pulse. The block shapes that character according to the selected terminal mode, latches it into an input buffer that the CPU can read at any time, and raises an input-ready flag. A break condition from the receiver loads a zero character and still raises the flag.

On the printer side a CPU write keeps the low character bits of the bus word and drops output-ready. The shaped character is then offered to a transmitter stub with a valid/ready handshake. Output-ready comes back only when the stub accepts the character, so a stalled transmitter keeps the character on offer for as long as it stalls. The CPU clears either flag with a function operation and tests them with a combinational skip output. Each flag, gated by its own interrupt-enable bit, feeds one registered interrupt request.

One mode setting governs both directions. The teletype-compatible mode forces 7-bit upper-case characters, and on input it also marks bit 7. The plain modes mask to 7 or 8 bits.

Top module: `console_char_if`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, rd_data is 0, in_ready is 0, out_ready is 1, tx_valid is 0 and irq is 0.
- R2: mode_sel encodes the mode, and the same mode applies to input and output: 2'b00 is seven-bit, 2'b01 is eight-bit, 2'b10 and 2'b11 are teletype mode.
- R3: In teletype mode a received character is cut to its low 7 bits. A value from 0x61 to 0x7A then has 0x20 subtracted, and bit 7 is set before the character is latched; 0x60 and 0x7B to 0x7F are kept unchanged.
- R4: Seven-bit mode masks a character with 0x7F and eight-bit mode masks it with 0xFF, in both directions.
- R5: In teletype mode an output character is cut to 7 bits and 0x61 to 0x7A is turned into upper case, with bit 7 left clear.
- R6: rx_valid together with rx_break loads 0 into the input buffer and sets in_ready in the next cycle, whatever the mode.
- R7: wr_en stores the low CHAR_W bits of wr_data. In the next cycle out_ready is 0 and tx_valid is 1.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1, tx_data keeps its character and out_ready stays 0. The cycle after a handshake with tx_ready 1, tx_valid is 0 and out_ready is 1.
- R9: fn_en with fn_clr_in clears in_ready in the next cycle, and fn_en with fn_clr_out clears out_ready in the next cycle. A character received, or a handshake completed, in the same cycle wins over the clear.
- R10: skip is combinational and equals (sk_in AND in_ready) OR (sk_out AND out_ready).
- R11: irq equals, one cycle later, (in_ready AND ien_in) OR (out_ready AND ien_out).
- R12: Without a function operation, in_ready and rd_data keep their values until the next received character. Reading does not clear them.
- R13: rd_data is the input buffer zero-extended to BUS_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Terminal mode, shared by both directions |
| rx_valid | input | 1 | One-cycle pulse: receiver has a character |
| rx_break | input | 1 | With rx_valid: the event is a break |
| rx_data | input | CHAR_W | Received raw character |
| rd_data | output | BUS_W | Input buffer, zero-extended |
| wr_en | input | 1 | CPU write strobe to the output side |
| wr_data | input | BUS_W | CPU write word |
| tx_valid | output | 1 | Character offered to the transmitter |
| tx_data | output | CHAR_W | Shaped output character |
| tx_ready | input | 1 | Transmitter accepts the offered character |
| fn_en | input | 1 | Function operation strobe |
| fn_clr_in | input | 1 | With fn_en: clear input-ready |
| fn_clr_out | input | 1 | With fn_en: clear output-ready |
| sk_in | input | 1 | Skip test selects input-ready |
| sk_out | input | 1 | Skip test selects output-ready |
| skip | output | 1 | Skip condition |
| ien_in | input | 1 | Input interrupt enable |
| ien_out | input | 1 | Output interrupt enable |
| in_ready | output | 1 | Input-ready flag |
| out_ready | output | 1 | Output-ready flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with CHAR_W of 8 and BUS_W of 16. With these widths, the upper byte of a write word has to be dropped and the upper byte of rd_data has to read as zero, so both cases get exercised. Eight-bit characters also reach the cases where the masks differ: bit 7 is set on input in teletype mode, and bit 7 is stripped in seven-bit mode. Holding tx_ready low for several cycles tests the retry path, and same-cycle clear-versus-set tests the flag priorities.

// File: rtl/cci_pkg.sv
package cci_pkg;
   typedef enum logic [1:0] {
      CM_SEVEN = 2'b00,
      CM_EIGHT = 2'b01,
      CM_TTY_A = 2'b10,
      CM_TTY_B = 2'b11
   } cci_mode_t;

   localparam logic [6:0] LC_FIRST = 7'h61;
   localparam logic [6:0] LC_LAST  = 7'h7A;
   localparam logic [6:0] CASE_GAP = 7'h20;
endpackage

// File: rtl/cci_shaper.sv
module cci_shaper
   import cci_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter bit SET_MARK = 1'b0
) (
   input  cci_mode_t          mode,
   input  logic [CHAR_W-1:0]  raw,
   output logic [CHAR_W-1:0]  shaped
);
   localparam int LOW_W = 7;

   logic [LOW_W-1:0] low7;
   logic             is_lower;
   logic [LOW_W-1:0] upper7;
   logic [7:0]       tty_byte;

   assign low7     = raw[LOW_W-1:0];
   assign is_lower = (low7 >= LC_FIRST) && (low7 <= LC_LAST);
   assign upper7   = is_lower ? (low7 - CASE_GAP) : low7;

   generate
      if (SET_MARK) begin : g_mark
         assign tty_byte = {1'b1, upper7};
      end else begin : g_plain
         assign tty_byte = {1'b0, upper7};
      end
   endgenerate

   always_comb begin
      case (mode)
         CM_SEVEN: shaped = CHAR_W'(low7);
         CM_EIGHT: shaped = CHAR_W'(raw[7:0]);
         default:  shaped = CHAR_W'(tty_byte);
      endcase
   end
endmodule

// File: rtl/cci_in_path.sv
module cci_in_path
   import cci_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  cci_mode_t          mode,
   input  logic               rx_valid,
   input  logic               rx_break,
   input  logic [CHAR_W-1:0]  rx_data,
   input  logic               clr,
   output logic [CHAR_W-1:0]  buf_q,
   output logic               rdy_q
);
   logic [CHAR_W-1:0] shaped;

   cci_shaper #(.CHAR_W(CHAR_W), .SET_MARK(1'b1)) u_shape (
      .mode   (mode),
      .raw    (rx_data),
      .shaped (shaped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         rdy_q <= 1'b0;
      end else if (rx_valid) begin
         buf_q <= rx_break ? '0 : shaped;
         rdy_q <= 1'b1;
      end else if (clr) begin
         rdy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cci_out_path.sv
module cci_out_path
   import cci_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  cci_mode_t          mode,
   input  logic               wr_en,
   input  logic [CHAR_W-1:0]  wr_char,
   input  logic               clr,
   input  logic               tx_ready,
   output logic               tx_valid,
   output logic [CHAR_W-1:0]  tx_data,
   output logic               rdy_q
);
   logic [CHAR_W-1:0] hold_q;
   logic              busy_q;

   cci_shaper #(.CHAR_W(CHAR_W), .SET_MARK(1'b0)) u_shape (
      .mode   (mode),
      .raw    (hold_q),
      .shaped (tx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         busy_q <= 1'b0;
         rdy_q  <= 1'b1;
      end else if (wr_en) begin
         hold_q <= wr_char;
         busy_q <= 1'b1;
         rdy_q  <= 1'b0;
      end else if (busy_q && tx_ready) begin
         busy_q <= 1'b0;
         rdy_q  <= 1'b1;
      end else if (clr) begin
         rdy_q  <= 1'b0;
      end
   end

   assign tx_valid = busy_q;
endmodule

// File: rtl/console_char_if.sv
module console_char_if
   import cci_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_sel,
   input  logic               rx_valid,
   input  logic               rx_break,
   input  logic [CHAR_W-1:0]  rx_data,
   output logic [BUS_W-1:0]   rd_data,
   input  logic               wr_en,
   input  logic [BUS_W-1:0]   wr_data,
   output logic               tx_valid,
   output logic [CHAR_W-1:0]  tx_data,
   input  logic               tx_ready,
   input  logic               fn_en,
   input  logic               fn_clr_in,
   input  logic               fn_clr_out,
   input  logic               sk_in,
   input  logic               sk_out,
   output logic               skip,
   input  logic               ien_in,
   input  logic               ien_out,
   output logic               in_ready,
   output logic               out_ready,
   output logic               irq
);
   localparam int PAD_W = BUS_W - CHAR_W;

   generate
      if (CHAR_W < 8) begin : g_bad_char
         $error("CHAR_W must be at least 8");
      end
      if (BUS_W < CHAR_W) begin : g_bad_bus
         $error("BUS_W must not be narrower than CHAR_W");
      end
   endgenerate

   cci_mode_t         mode;
   logic [CHAR_W-1:0] in_buf;
   logic              clr_in;
   logic              clr_out;
   logic              irq_next;

   assign mode    = cci_mode_t'(mode_sel);
   assign clr_in  = fn_en & fn_clr_in;
   assign clr_out = fn_en & fn_clr_out;

   cci_in_path #(.CHAR_W(CHAR_W)) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .rx_valid (rx_valid),
      .rx_break (rx_break),
      .rx_data  (rx_data),
      .clr      (clr_in),
      .buf_q    (in_buf),
      .rdy_q    (in_ready)
   );

   cci_out_path #(.CHAR_W(CHAR_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .wr_en    (wr_en),
      .wr_char  (wr_data[CHAR_W-1:0]),
      .clr      (clr_out),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .rdy_q    (out_ready)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^wr_data[BUS_W-1:CHAR_W];
         assign rd_data   = {{PAD_W{1'b0}}, in_buf};
      end else begin : g_flush
         assign rd_data = in_buf;
      end
   endgenerate

   assign skip     = (sk_in & in_ready) | (sk_out & out_ready);
   assign irq_next = (in_ready & ien_in) | (out_ready & ien_out);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_next;
   end
endmodule

// File: rtl/cci_checker.sv
module cci_checker #(
   parameter int CHAR_W = 8,
   parameter int BUS_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_sel,
   input logic               rx_valid,
   input logic               rx_break,
   input logic [BUS_W-1:0]   rd_data,
   input logic               wr_en,
   input logic               tx_valid,
   input logic [CHAR_W-1:0]  tx_data,
   input logic               tx_ready,
   input logic               fn_en,
   input logic               fn_clr_in,
   input logic               in_ready,
   input logic               out_ready,
   input logic               ien_in,
   input logic               ien_out,
   input logic               irq
);
   // R6: a break leaves a zero character and a raised flag
   a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_break |=> (rd_data == '0) && in_ready);

   // R3: teletype input always carries the mark bit
   a_r3_tty_mark: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_break && mode_sel[1] |=> rd_data[7]);

   // R4: seven-bit input never carries bit 7
   a_r4_seven_mask: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && (mode_sel == 2'b00) |=> !rd_data[7]);

   // R7: a write drops output-ready and offers a character
   a_r7_write_start: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !out_ready && tx_valid);

   // R8: a character on offer keeps output-ready low
   a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !out_ready);

   // R8: stalled offer is held
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !wr_en && $stable(mode_sel) |=> tx_valid && $stable(tx_data));

   // R8: handshake restores output-ready
   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && !wr_en |=> out_ready && !tx_valid);

   // R9: function clear of input-ready
   a_r9_clear_in: assert property (@(posedge clk) disable iff (!rst_n)
      fn_en && fn_clr_in && !rx_valid |=> !in_ready);

   // R12: no clear and no character keeps flag and buffer
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid && !(fn_en && fn_clr_in) |=> $stable(rd_data) && (in_ready == $past(in_ready)));

   // R11: registered request
   a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> irq == $past((in_ready && ien_in) || (out_ready && ien_out)));
endmodule

bind console_char_if cci_checker #(.CHAR_W(CHAR_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/console_char_if_tb_top.sv
module console_char_if_tb_top;
   localparam int CLK_P  = 10;
   localparam int CHAR_W = 8;
   localparam int BUS_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_sel = 2'b10;
   logic              rx_valid = 1'b0, rx_break = 1'b0;
   logic [CHAR_W-1:0] rx_data = '0;
   logic [BUS_W-1:0]  rd_data;
   logic              wr_en = 1'b0;
   logic [BUS_W-1:0]  wr_data = '0;
   logic              tx_valid;
   logic [CHAR_W-1:0] tx_data;
   logic              tx_ready = 1'b1;
   logic              fn_en = 1'b0, fn_clr_in = 1'b0, fn_clr_out = 1'b0;
   logic              sk_in = 1'b0, sk_out = 1'b0;
   logic              skip;
   logic              ien_in = 1'b0, ien_out = 1'b0;
   logic              in_ready, out_ready, irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [CHAR_W-1:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   console_char_if #(.CHAR_W(CHAR_W), .BUS_W(BUS_W)) dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] up7(input logic [7:0] d);
      logic [6:0] c;
      c = d[6:0];
      if (c >= 7'h61 && c <= 7'h7A) c = c - 7'h20;
      return {1'b0, c};
   endfunction

   function automatic logic [7:0] exp_in(input logic [1:0] m, input logic [7:0] d);
      if (m == 2'b00) return d & 8'h7F;
      if (m == 2'b01) return d;
      return up7(d) | 8'h80;
   endfunction

   function automatic logic [7:0] exp_out(input logic [1:0] m, input logic [7:0] d);
      if (m == 2'b00) return d & 8'h7F;
      if (m == 2'b01) return d;
      return up7(d);
   endfunction

   // receive one character; results checked one negedge later
   task automatic receive(input logic [7:0] d, input logic brk, input string tag);
      @(negedge clk);
      rx_data = d; rx_break = brk; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
      check({tag, " rd_data"}, 32'(rd_data), brk ? 32'h0 : 32'(exp_in(mode_sel, d)));
      check({tag, " in_ready"}, 32'(in_ready), 32'h1);
   endtask

   // driver: write a word, push the expected transmitted character
   task automatic send(input logic [BUS_W-1:0] w, input string tag);
      @(negedge clk);
      wr_data = w; wr_en = 1'b1;
      exp_q.push_back(exp_out(mode_sel, w[7:0]));
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " out_ready low"}, 32'(out_ready), 32'h0);
      check({tag, " tx_valid"}, 32'(tx_valid), 32'h1);
   endtask

   task automatic drain();
      int guard = 0;
      while ((tx_valid || exp_q.size() != 0) && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   // monitor: pop and compare on each handshake
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected handshake", 32'(tx_data), 32'hFFFF);
            end else begin
               check("R5/R4/R7 tx_data", 32'(tx_data), 32'(exp_q.pop_front()));
            end
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      ien_out = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 rd_data in reset", 32'(rd_data), 32'h0);
      check("R1 out_ready in reset", 32'(out_ready), 32'h1);
      check("R1 irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      ien_out = 1'b0;
      check("R1 in_ready", 32'(in_ready), 32'h0);
      check("R1 tx_valid", 32'(tx_valid), 32'h0);

      // R3 teletype input
      mode_sel = 2'b10;
      receive(8'h61, 1'b0, "R3 a");
      receive(8'h7A, 1'b0, "R3 z");
      receive(8'hE1, 1'b0, "R3 high a");
      receive(8'h7B, 1'b0, "R3 brace");
      receive(8'h60, 1'b0, "R3 grave");
      mode_sel = 2'b11;
      receive(8'h6D, 1'b0, "R2 mode11 m");
      // R4 masking on input
      mode_sel = 2'b00;
      receive(8'hE1, 1'b0, "R4 seven");
      mode_sel = 2'b01;
      receive(8'hE1, 1'b0, "R4 eight");
      check("R13 upper rd_data", 32'(rd_data[BUS_W-1:CHAR_W]), 32'h0);

      // R9 clear, R12 sticky
      @(negedge clk);
      fn_en = 1'b1; fn_clr_in = 1'b1;
      @(negedge clk);
      fn_en = 1'b0; fn_clr_in = 1'b0;
      check("R9 clear in_ready", 32'(in_ready), 32'h0);
      check("R12 rd_data kept", 32'(rd_data), 32'hE1);
      // R10 skip
      sk_in = 1'b1; #1;
      check("R10 skip in clear", 32'(skip), 32'h0);
      sk_in = 1'b0; sk_out = 1'b1; #1;
      check("R10 skip out set", 32'(skip), 32'h1);
      sk_out = 1'b0; #1;
      check("R10 skip none", 32'(skip), 32'h0);

      // R6 break in teletype mode
      mode_sel = 2'b10;
      receive(8'h41, 1'b1, "R6 break");
      repeat (3) @(negedge clk);
      check("R12 in_ready held", 32'(in_ready), 32'h1);
      check("R12 rd_data held", 32'(rd_data), 32'h0);
      sk_in = 1'b1; #1;
      check("R10 skip in set", 32'(skip), 32'h1);
      sk_in = 1'b0;

      // R11 irq
      ien_in = 1'b1;
      @(negedge clk);
      check("R11 irq from input", 32'(irq), 32'h1);
      ien_in = 1'b0;
      @(negedge clk);
      check("R11 irq off", 32'(irq), 32'h0);

      // R9 set wins over clear
      @(negedge clk);
      rx_data = 8'h31; rx_valid = 1'b1; fn_en = 1'b1; fn_clr_in = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; fn_en = 1'b0; fn_clr_in = 1'b0;
      check("R9 rx wins", 32'(in_ready), 32'h1);

      // output side, R5 teletype
      mode_sel = 2'b10;
      send(16'h1261, "R7 R5 a");
      drain();
      check("R8 out_ready back", 32'(out_ready), 32'h1);
      mode_sel = 2'b11;
      send(16'hAAFA, "R5 high z");
      drain();
      mode_sel = 2'b00;
      send(16'h00E1, "R4 out seven");
      drain();

      // R8 backpressure in eight-bit mode
      mode_sel = 2'b01;
      tx_ready = 1'b0;
      send(16'h55E1, "R8 stall");
      repeat (5) @(negedge clk);
      check("R8 held valid", 32'(tx_valid), 32'h1);
      check("R8 held data", 32'(tx_data), 32'hE1);
      check("R8 ready low", 32'(out_ready), 32'h0);
      ien_out = 1'b1;
      @(negedge clk);
      check("R11 no irq while busy", 32'(irq), 32'h0);
      tx_ready = 1'b1;
      drain();
      check("R8 ready after accept", 32'(out_ready), 32'h1);
      check("R11 irq from output", 32'(irq), 32'h1);
      ien_out = 1'b0;

      // R9 clear output-ready
      @(negedge clk);
      fn_en = 1'b1; fn_clr_out = 1'b1;
      @(negedge clk);
      fn_en = 1'b0; fn_clr_out = 1'b0;
      check("R9 clear out_ready", 32'(out_ready), 32'h0);
      check("R9 no offer", 32'(tx_valid), 32'h0);

      // R9 accept wins over clear
      tx_ready = 1'b0;
      send(16'h0042, "R9 race");
      @(negedge clk);
      tx_ready = 1'b1; fn_en = 1'b1; fn_clr_out = 1'b1;
      @(negedge clk);
      fn_en = 1'b0; fn_clr_out = 1'b0;
      check("R9 accept wins", 32'(out_ready), 32'h1);

      drain();
      check("R8 scoreboard empty", 32'(exp_q.size()), 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule